// File: doc/BRIEF.md
# Translation Table Pointer Generator

This block forms the two memory pointers that a software translation-miss handler uses to locate candidate entries in its in-memory translation tables, one for each of two page-size groups. It also forms the tag-target word the handler compares against a table entry. The inputs are the most recent tag-access value, four table base registers and two configuration registers. The base and configuration registers come in two sets: one for the zero context and one for every other context.

A one-cycle read strobe samples all inputs. One clock later the pointers and the tag-target word appear on registered outputs, with a valid flag. The outputs hold their value until the next strobe.

Each pointer starts from the upper bits of the selected base. The tag-access value is shifted right by an amount set by the configured page size. That shifted value is masked to a window whose width the configured table size sets, and the result is merged into the pointer. The second group can also be split, which sets one extra offset bit.

Top module: `ttp_gen`

## Requirements
- R1: While reset is asserted and after reset until the first strobe, `ptr0`, `ptr1` and `tag_word` are zero and `rd_valid` is low.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_stb` high, and low otherwise.
- R3: When `tag_acc[12:0]` is zero, the zero-context base and configuration registers are used. Otherwise the nonzero-context registers are used.
- R4: Pointer bits 63:13 include the selected base bits 63:13, merged by OR. Base bits 12:0 never appear directly.
- R5: The index is `tag_acc` shifted right by 9 + 3·P, where P is configuration bits 2:0 (0 to 7). The same P is used for both groups.
- R6: The index is masked to bits 4 through 12+S, where S is base bits 3:0 of that group's base. Pointer bits 3:0 are always zero.
- R7: For group 1 only, when base bit 12 is set, pointer bit 13+S is also set. Base bit 12 has no effect on group 0.
- R8: `tag_word` bits 41:0 equal `tag_acc[63:22]`, and bits 60:48 equal `tag_acc[12:0]`. All other bits are zero.
- R9: Input changes while `rd_stb` is low do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Sample inputs and compute outputs |
| tag_acc | input | 64 | Tag-access value: page address high, context in bits 12:0 |
| z_base0 | input | 64 | Zero-context table base, group 0 |
| z_base1 | input | 64 | Zero-context table base, group 1 |
| nz_base0 | input | 64 | Nonzero-context table base, group 0 |
| nz_base1 | input | 64 | Nonzero-context table base, group 1 |
| z_cfg | input | 64 | Zero-context configuration (page size in bits 2:0) |
| nz_cfg | input | 64 | Nonzero-context configuration (page size in bits 2:0) |
| ptr0 | output | 64 | Pointer for page-size group 0 |
| ptr1 | output | 64 | Pointer for page-size group 1 |
| tag_word | output | 64 | Tag-target word |
| rd_valid | output | 1 | Outputs updated this cycle |

## Verification
On every cycle, the assertions check the following:
- the strobe-to-valid timing;
- that the outputs stay stable between strobes;
- that pointers are 16-byte aligned;
- that the pointer bits above the widest index window come from the base selected by context;
- that the tag word has zeros where it must.

Only the directed scenarios can show the exact arithmetic. These cover the shift for each page-size code, the mask width for small and large table sizes, the split bit on one group and not the other, and the exact placement of the context bits in the tag word.

// File: rtl/ttp_pkg.sv
package ttp_pkg;
   localparam int unsigned DATA_W    = 64;
   localparam int unsigned CTX_W     = 13;
   localparam int unsigned PS_W      = 3;
   localparam int unsigned SZ_W      = 4;
   localparam int unsigned BASE_LSB  = 13;
   localparam int unsigned IDX_SHIFT = 9;
   localparam int unsigned PS_STEP   = 3;
   localparam int unsigned ENT_ALIGN = 4;
   localparam int unsigned WIN_TOP0  = 12;
   localparam int unsigned TW_SHIFT  = 22;
   localparam int unsigned TW_CTXPOS = 48;

   typedef struct packed {
      logic [DATA_W-1:0] base0;
      logic [DATA_W-1:0] base1;
      logic [DATA_W-1:0] cfg;
   } ttp_regset_t;
endpackage

// File: rtl/ttp_ctx_mux.sv
module ttp_ctx_mux
   import ttp_pkg::*;
#(
   parameter int unsigned W    = DATA_W,
   parameter int unsigned CW   = CTX_W
) (
   input  logic [W-1:0] tag_acc,
   input  logic [W-1:0] z_base0,
   input  logic [W-1:0] z_base1,
   input  logic [W-1:0] z_cfg,
   input  logic [W-1:0] nz_base0,
   input  logic [W-1:0] nz_base1,
   input  logic [W-1:0] nz_cfg,
   output logic [W-1:0] sel_base0,
   output logic [W-1:0] sel_base1,
   output logic [W-1:0] sel_cfg
);
   logic zero_ctx;

   if (CW == 0 || CW >= W) begin : g_bad_ctx
      $error("ttp_ctx_mux: context width out of range");
   end

   assign zero_ctx = (tag_acc[CW-1:0] == '0);

   always_comb begin
      if (zero_ctx) begin
         sel_base0 = z_base0;
         sel_base1 = z_base1;
         sel_cfg   = z_cfg;
      end else begin
         sel_base0 = nz_base0;
         sel_base1 = nz_base1;
         sel_cfg   = nz_cfg;
      end
   end
endmodule

// File: rtl/ttp_ptr_calc.sv
module ttp_ptr_calc
   import ttp_pkg::*;
#(
   parameter int unsigned W       = DATA_W,
   parameter int unsigned PSW     = PS_W,
   parameter int unsigned SZW     = SZ_W,
   parameter int unsigned BLSB    = BASE_LSB,
   parameter int unsigned SHIFT0  = IDX_SHIFT,
   parameter int unsigned STEP    = PS_STEP,
   parameter int unsigned ALIGN   = ENT_ALIGN,
   parameter int unsigned TOP0    = WIN_TOP0,
   parameter bit          SPLIT_EN = 1'b0
) (
   input  logic [W-1:0] tag_acc,
   input  logic [W-1:0] base,
   input  logic [W-1:0] cfg,
   output logic [W-1:0] ptr
);
   localparam int unsigned PS_MAX  = (1 << PSW) - 1;
   localparam int unsigned SZ_MAX  = (1 << SZW) - 1;
   localparam int unsigned SH_MAX  = SHIFT0 + STEP * PS_MAX;
   localparam int unsigned TOP_MAX = TOP0 + SZ_MAX;
   localparam int unsigned SPL_MAX = BLSB + SZ_MAX;
   localparam int unsigned CW      = $clog2(W) + 1;

   if (SH_MAX >= W || TOP_MAX >= W || SPL_MAX >= W) begin : g_bad_range
      $error("ttp_ptr_calc: shift or window exceeds data width");
   end
   if (ALIGN > TOP0 || BLSB <= SZW || BLSB >= W) begin : g_bad_layout
      $error("ttp_ptr_calc: inconsistent field layout");
   end

   logic [PSW-1:0] ps;
   logic [SZW-1:0] sz;
   logic [CW-1:0]  shamt;
   logic [CW-1:0]  top;
   logic [W-1:0]   idx;
   logic [W-1:0]   win;
   logic [W-1:0]   hi_base;
   logic [W-1:0]   split_bit;

   assign ps    = cfg[PSW-1:0];
   assign sz    = base[SZW-1:0];
   assign shamt = CW'(SHIFT0) + CW'(STEP) * CW'(ps);
   assign top   = CW'(TOP0) + CW'(sz);
   assign idx   = tag_acc >> shamt;

   always_comb begin
      for (int i = 0; i < int'(W); i++) begin
         win[i] = (i >= int'(ALIGN)) && (i <= int'(top));
      end
   end

   assign hi_base = {base[W-1:BLSB], {BLSB{1'b0}}};

   if (SPLIT_EN) begin : g_split
      logic [CW-1:0] spos;
      assign spos      = CW'(BLSB) + CW'(sz);
      assign split_bit = base[BLSB-1] ? (W'(1) << spos) : '0;
   end else begin : g_nosplit
      assign split_bit = '0;
   end

   assign ptr = hi_base | (idx & win) | split_bit;
endmodule

// File: rtl/ttp_tag_word.sv
module ttp_tag_word
   import ttp_pkg::*;
#(
   parameter int unsigned W    = DATA_W,
   parameter int unsigned CW   = CTX_W,
   parameter int unsigned SH   = TW_SHIFT,
   parameter int unsigned CPOS = TW_CTXPOS
) (
   input  logic [W-1:0] tag_acc,
   output logic [W-1:0] tag_word
);
   localparam int unsigned VA_BITS = W - SH;

   if (CPOS + CW > W || VA_BITS > CPOS) begin : g_bad_tw
      $error("ttp_tag_word: fields overlap or overflow");
   end

   logic [W-1:0] va_part;
   logic [W-1:0] ctx_part;

   assign va_part  = W'(tag_acc[W-1:SH]);
   assign ctx_part = W'(tag_acc[CW-1:0]) << CPOS;
   assign tag_word = va_part | ctx_part;
endmodule

// File: rtl/ttp_gen.sv
module ttp_gen
   import ttp_pkg::*;
#(
   parameter int unsigned W = DATA_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_stb,
   input  logic [63:0]  tag_acc,
   input  logic [63:0]  z_base0,
   input  logic [63:0]  z_base1,
   input  logic [63:0]  nz_base0,
   input  logic [63:0]  nz_base1,
   input  logic [63:0]  z_cfg,
   input  logic [63:0]  nz_cfg,
   output logic [63:0]  ptr0,
   output logic [63:0]  ptr1,
   output logic [63:0]  tag_word,
   output logic         rd_valid
);
   localparam int unsigned NGRP = 2;

   if (W != 64) begin : g_bad_w
      $error("ttp_gen: port width fixed at 64");
   end

   logic [W-1:0] sel_base [NGRP];
   logic [W-1:0] sel_cfg;
   logic [W-1:0] ptr_nx   [NGRP];
   logic [W-1:0] tw_nx;

   ttp_ctx_mux #(.W(W), .CW(CTX_W)) u_mux (
      .tag_acc   (tag_acc),
      .z_base0   (z_base0),
      .z_base1   (z_base1),
      .z_cfg     (z_cfg),
      .nz_base0  (nz_base0),
      .nz_base1  (nz_base1),
      .nz_cfg    (nz_cfg),
      .sel_base0 (sel_base[0]),
      .sel_base1 (sel_base[1]),
      .sel_cfg   (sel_cfg)
   );

   for (genvar g = 0; g < int'(NGRP); g++) begin : g_grp
      ttp_ptr_calc #(
         .W        (W),
         .SPLIT_EN (g == 1)
      ) u_calc (
         .tag_acc (tag_acc),
         .base    (sel_base[g]),
         .cfg     (sel_cfg),
         .ptr     (ptr_nx[g])
      );
   end

   ttp_tag_word #(.W(W)) u_tw (
      .tag_acc  (tag_acc),
      .tag_word (tw_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr0     <= '0;
         ptr1     <= '0;
         tag_word <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_stb;
         if (rd_stb) begin
            ptr0     <= ptr_nx[0];
            ptr1     <= ptr_nx[1];
            tag_word <= tw_nx;
         end
      end
   end
endmodule

// File: rtl/ttp_gen_chk.sv
module ttp_gen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rd_stb,
   input logic [63:0] tag_acc,
   input logic [63:0] z_base0,
   input logic [63:0] nz_base0,
   input logic [63:0] z_base1,
   input logic [63:0] nz_base1,
   input logic [63:0] ptr0,
   input logic [63:0] ptr1,
   input logic [63:0] tag_word,
   input logic        rd_valid
);
   localparam int unsigned HI = 29;

   p_valid_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rd_valid);
   p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> !rd_valid);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> ($stable(ptr0) && $stable(ptr1) && $stable(tag_word)));
   p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (ptr0[3:0] == 4'h0 && ptr1[3:0] == 4'h0));
   p_base_sel0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ptr0[63:HI] == (($past(tag_acc[12:0]) == 13'd0)
                                  ? $past(z_base0[63:HI]) : $past(nz_base0[63:HI])));
   p_base_sel1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ptr1[63:HI] == (($past(tag_acc[12:0]) == 13'd0)
                                  ? $past(z_base1[63:HI]) : $past(nz_base1[63:HI])));
   p_tw_zeros_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (tag_word[63:61] == 3'd0 && tag_word[47:42] == 6'd0));
endmodule

bind ttp_gen ttp_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_stb   (rd_stb),
   .tag_acc  (tag_acc),
   .z_base0  (z_base0),
   .nz_base0 (nz_base0),
   .z_base1  (z_base1),
   .nz_base1 (nz_base1),
   .ptr0     (ptr0),
   .ptr1     (ptr1),
   .tag_word (tag_word),
   .rd_valid (rd_valid)
);

// File: tb/tb_ttp_gen.sv
module tb_ttp_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_stb = 1'b0;
   logic [63:0] tag_acc = '0, z_base0 = '0, z_base1 = '0, nz_base0 = '0, nz_base1 = '0;
   logic [63:0] z_cfg = '0, nz_cfg = '0;
   logic [63:0] ptr0, ptr1, tag_word;
   logic        rd_valid;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ttp_gen dut (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .tag_acc(tag_acc),
      .z_base0(z_base0), .z_base1(z_base1), .nz_base0(nz_base0), .nz_base1(nz_base1),
      .z_cfg(z_cfg), .nz_cfg(nz_cfg),
      .ptr0(ptr0), .ptr1(ptr1), .tag_word(tag_word), .rd_valid(rd_valid)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [63:0] ta, input logic [63:0] b,
                                         input logic [63:0] c, input bit grp1);
      int sz = int'(b[3:0]);
      int sh = 9 + 3 * int'(c[2:0]);
      logic [63:0] r = b & ~64'h1FFF;
      for (int k = 4; k <= 12 + sz; k++) r[k] = r[k] | ta[k + sh];
      if (grp1 && b[12]) r[13 + sz] = 1'b1;
      return r;
   endfunction

   function automatic logic [63:0] tw_model(input logic [63:0] ta);
      logic [63:0] r = '0;
      for (int k = 0; k < 42; k++) r[k] = ta[22 + k];
      for (int k = 0; k < 13; k++) r[48 + k] = ta[k];
      return r;
   endfunction

   // strobe for one cycle, then check at the following negedge
   task automatic pulse_and_check(input string tag);
      logic zc;
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      zc = (tag_acc[12:0] == 13'd0);
      chk({tag, " valid R2"}, 64'(rd_valid), 64'd1);
      chk({tag, " ptr0"}, ptr0, model(tag_acc, zc ? z_base0 : nz_base0, zc ? z_cfg : nz_cfg, 1'b0));
      chk({tag, " ptr1"}, ptr1, model(tag_acc, zc ? z_base1 : nz_base1, zc ? z_cfg : nz_cfg, 1'b1));
      chk({tag, " tag_word R8"}, tag_word, tw_model(tag_acc));
   endtask

   task automatic t_reset();
      chk("R1 ptr0", ptr0, '0);
      chk("R1 ptr1", ptr1, '0);
      chk("R1 tag_word", tag_word, '0);
      chk("R1 valid", 64'(rd_valid), '0);
   endtask

   task automatic t_ctx_select();
      z_base0 = 64'hAAAA_0000_0000_2002; nz_base0 = 64'h5555_0000_0000_4003;
      z_base1 = 64'h1111_0000_0000_6001; nz_base1 = 64'h2222_0000_0000_8004;
      z_cfg = 64'd1; nz_cfg = 64'd2;
      tag_acc = 64'hFEDC_BA98_7654_2000;
      pulse_and_check("R3 R4 zero ctx");
      chk("R3 zero ctx base0", {ptr0[63:29], 29'd0}, {z_base0[63:29], 29'd0});
      tag_acc = 64'hFEDC_BA98_7654_2001;
      pulse_and_check("R3 R4 nonzero ctx");
      chk("R3 nonzero ctx base0", {ptr0[63:29], 29'd0}, {nz_base0[63:29], 29'd0});
   endtask

   task automatic t_shift_sweep();
      nz_base0 = 64'h0000_4000_0000_000F;
      nz_base1 = 64'h0000_8000_0000_000F;
      tag_acc = 64'h0F1E_2D3C_4B5A_6979;
      for (int p = 0; p < 8; p++) begin
         nz_cfg = 64'(p);
         pulse_and_check($sformatf("R5 ps=%0d", p));
      end
   endtask

   task automatic t_size_sweep();
      tag_acc = 64'hFFFF_FFFF_FFFF_E005;
      nz_cfg = 64'd0;
      for (int s = 0; s < 16; s += 5) begin
         nz_base0 = 64'h8000_0000_0000_0000 | 64'(s);
         nz_base1 = 64'h8000_0000_0000_0000 | 64'(s);
         pulse_and_check($sformatf("R6 sz=%0d", s));
         chk("R6 low nibble", 64'(ptr0[3:0]), 64'd0);
      end
   endtask

   task automatic t_split();
      tag_acc = 64'h0000_0000_0000_0001;
      nz_cfg = 64'd0;
      nz_base0 = 64'h0000_0000_0000_1003;
      nz_base1 = 64'h0000_0000_0000_1003;
      pulse_and_check("R7 split");
      chk("R7 group1 split bit", ptr1, 64'h0000_0000_0001_0000);
      chk("R7 group0 unaffected", ptr0, 64'h0);
   endtask

   task automatic t_tag_word();
      tag_acc = 64'h1234_5678_9ABC_DFFF;
      pulse_and_check("R8 ctx all ones");
      chk("R8 ctx field", 64'(tag_word[60:48]), 64'h1FFF);
   endtask

   task automatic t_hold();
      logic [63:0] h0, h1, ht;
      h0 = ptr0; h1 = ptr1; ht = tag_word;
      tag_acc = ~tag_acc; nz_base0 = ~nz_base0; nz_base1 = ~nz_base1; nz_cfg = 64'd5;
      repeat (3) @(negedge clk);
      chk("R9 ptr0 hold", ptr0, h0);
      chk("R9 ptr1 hold", ptr1, h1);
      chk("R9 tag_word hold", tag_word, ht);
      chk("R2 valid low idle", 64'(rd_valid), 64'd0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_ctx_select();
            t_shift_sweep();
            t_size_sweep();
            t_split();
            t_tag_word();
            t_hold();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule